// File: doc/BRIEF.md
# Two-Port Register-Output RAM with Selectable Same-Address Policy

This block is a single-clock memory with one write port and one read port. A write is committed at the rising edge when its enable is high. A read presents its address in one cycle, and the word appears on a registered output in the next cycle. Both ports can be used in every cycle, so a read and a write can target the same location in the same cycle.

A compile-time parameter sets what the read returns when that same-address overlap happens:
- `RD_POLICY` = 0 returns the contents from before the write. This suits a full FIFO that pops and refills one slot in the same cycle.
- `RD_POLICY` = 1 returns the word being written. This suits a register bank whose next instruction reads what the previous one stored.
- `RD_POLICY` = 2 leaves the output unchanged for that cycle.

Any other value is rejected at elaboration.

The storage cells have no reset, so they can map onto dense memory. A synchronous reset clears only the output register. The memory accepts a read and a write in every cycle and never stalls, so both ports are plain enable/address/data pins with no back-pressure.

Top module: `tp_ram`

## Requirements
- R1: A write with `wr_en` low leaves the addressed word unchanged, as a later read shows.
- R2: With `rd_en` high at edge N, `rd_data` shows the word for `rd_addr` after edge N and holds it until the next read edge.
- R3: When the read and write addresses differ, or no write is active, every policy returns the stored word of `rd_addr`.
- R4: With `RD_POLICY`=0, a read and a write to the same address in one cycle return the word stored before the write.
- R5: With `RD_POLICY`=1, a read and a write to the same address in one cycle return the written word.
- R6: With `RD_POLICY`=2, a read and a write to the same address in one cycle leave `rd_data` at its previous value.
- R7: While `rd_en` is low, `rd_data` holds its value under every policy, even when the last-read location is rewritten.
- R8: A low `rst_n` at an edge clears `rd_data` to zero. The stored words keep their values through reset.
- R9: A read in the cycle right after a write to the same address returns the new word under every policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the output register only |
| wr_en | input | 1 | Commit `wr_data` at this edge |
| wr_addr | input | ADDR_W | Write location |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Load the output register at this edge |
| rd_addr | input | ADDR_W | Read location |
| rd_data | output | DATA_W | Registered read word |

## Verification
A corrupted cell shows up only when that location is next read, one edge after the read request. For this reason the bench first fills every address and then reads all of them back. A wrong overlap policy changes `rd_data` in the cycle right after the colliding edge, and it does so only on the instance built with that policy. All three policies are therefore run side by side on identical stimulus. A leaking output enable shows as a `rd_data` change during idle cycles in which the last-read location is rewritten.

// File: rtl/tp_ram_pkg.sv
package tp_ram_pkg;
  localparam int POL_OLD  = 0;
  localparam int POL_NEW  = 1;
  localparam int POL_KEEP = 2;

  function automatic bit policy_valid(input int p);
    return (p == POL_OLD) || (p == POL_NEW) || (p == POL_KEEP);
  endfunction
endpackage

// File: rtl/tp_ram_cells.sv
module tp_ram_cells #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rword
);
  // No reset on the cells: lets the array map onto dense memory.
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // Asynchronous look-up; sees the contents from before this edge's write.
  assign rword = cells[raddr];
endmodule

// File: rtl/tp_ram_rdstage.sv
module tp_ram_rdstage
  import tp_ram_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int RD_POLICY = POL_OLD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] arr_word,
  output logic [DATA_W-1:0] rd_data
);
  logic              overlap;
  logic [DATA_W-1:0] next_word;
  logic [DATA_W-1:0] out_q;

  assign overlap = wr_en && (wr_addr == rd_addr);

  // Policy mux in front of the one output register.
  always_comb begin
    next_word = arr_word;
    if (overlap) begin
      if (RD_POLICY == POL_NEW)       next_word = wr_data;
      else if (RD_POLICY == POL_KEEP) next_word = out_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     out_q <= '0;
    else if (rd_en) out_q <= next_word;
  end

  assign rd_data = out_q;

  generate
    if (!policy_valid(RD_POLICY)) begin : g_bad_policy
      $error("tp_ram: RD_POLICY must be 0, 1 or 2");
    end
  endgenerate

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_raw_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_en && (rd_addr == $past(wr_addr)) && !overlap)
      |=> rd_data == $past(wr_data, 2));

  generate
    if (RD_POLICY == POL_OLD) begin : g_chk_old
      assert_old_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && overlap) |=> rd_data == $past(arr_word));
    end else if (RD_POLICY == POL_NEW) begin : g_chk_new
      assert_new_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && overlap) |=> rd_data == $past(wr_data));
    end else begin : g_chk_keep
      assert_keep_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && overlap) |=> $stable(rd_data));
    end
  endgenerate
endmodule

// File: rtl/tp_ram.sv
module tp_ram
  import tp_ram_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 16,
  parameter int RD_POLICY = POL_OLD,
  localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] arr_word;

  tp_ram_cells #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cells (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rword(arr_word)
  );

  tp_ram_rdstage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_POLICY(RD_POLICY)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arr_word(arr_word), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_tp_ram.sv
`timescale 1ns/1ps
module tb_tp_ram;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] q_old, q_new, q_keep;

  tp_ram #(.DATA_W(DW), .DEPTH(DEPTH), .RD_POLICY(0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_old));
  tp_ram #(.DATA_W(DW), .DEPTH(DEPTH), .RD_POLICY(1)) dut_new (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_new));
  tp_ram #(.DATA_W(DW), .DEPTH(DEPTH), .RD_POLICY(2)) dut_keep (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_keep));

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] sb_old[$], sb_new[$], sb_keep[$];
  string sb_tag[$];

  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] e_old = '0, e_new = '0, e_keep = '0;

  // Driver: apply one cycle of stimulus, push the expected outputs.
  task automatic cyc(input logic rs, input logic we, input logic [AW-1:0] wa,
                     input logic [DW-1:0] wd, input logic re, input logic [AW-1:0] ra,
                     input string tag);
    @(negedge clk);
    rst_n = rs; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    if (!rs) begin
      e_old = '0; e_new = '0; e_keep = '0;
    end else if (re) begin
      if (we && wa == ra) begin
        e_old = mdl[ra]; e_new = wd;
      end else begin
        e_old = mdl[ra]; e_new = mdl[ra]; e_keep = mdl[ra];
      end
    end
    if (we) mdl[wa] = wd;
    sb_old.push_back(e_old); sb_new.push_back(e_new);
    sb_keep.push_back(e_keep); sb_tag.push_back(tag);
  endtask

  task automatic cmp(input string tag, input string pol, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s policy=%s actual=%h expected=%h", tag, pol, act, exp);
    end
  endtask

  // Monitor: compare after each edge against the entry pushed before it.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb_tag.size() > 0) begin
        string t;
        t = sb_tag.pop_front();
        cmp(t, "old",  q_old,  sb_old.pop_front());
        cmp(t, "new",  q_new,  sb_new.pop_front());
        cmp(t, "keep", q_keep, sb_keep.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0, "R8 reset state");
    // Fill with rd_en low: outputs must stay at zero.
    for (int i = 0; i < DEPTH; i++) cyc(1, 1, AW'(i), DW'(16'hA000 + i * 16'h0111), 0, 0, "R7 idle while filling");
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0, 0, 1, AW'(i), "R2 R3 readback");
    cyc(1, 1, 9, 16'h9999, 1, 5, "R3 distinct addresses");
    cyc(1, 0, 0, 0, 1, 9, "R3 R9 read after write");
    cyc(1, 1, 4, 16'h4444, 1, 4, "R4 R5 R6 overlap");
    cyc(1, 0, 0, 0, 1, 4, "R9 new word next cycle");
    cyc(1, 0, 6, 16'hDEAD, 1, 2, "R1 disabled write");
    cyc(1, 0, 0, 0, 1, 6, "R1 word unchanged");
    cyc(1, 1, 6, 16'h6060, 0, 6, "R7 rewrite while idle");
    cyc(1, 1, 6, 16'h6161, 0, 3, "R7 idle");
    cyc(1, 1, 1, 16'h1111, 1, 1, "R6 overlap run");
    cyc(1, 1, 2, 16'h2222, 1, 2, "R6 overlap run");
    cyc(1, 1, 3, 16'h3333, 1, 3, "R4 R5 R6 overlap run");
    cyc(1, 0, 0, 0, 1, 7, "R3 plain read");
    cyc(0, 0, 0, 0, 1, 9, "R8 mid-run reset");
    cyc(1, 0, 0, 0, 0, 9, "R8 R7 stays cleared");
    cyc(1, 0, 0, 0, 1, 9, "R8 contents kept");
    cyc(1, 0, 0, 0, 1, 6, "R8 contents kept");
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(1, lf[0], lf[4:1], lf ^ 16'h5A5A, lf[5] | lf[6], lf[2] ? lf[4:1] : lf[10:7],
          "R2 R3 R4 R5 R6 mixed");
    end
    cyc(1, 0, 0, 0, 0, 0, "R7 drain");
    @(posedge clk); #2;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule